// File: doc/BRIEF.md
# Sample Pulse Conditioning and Output Pipeline

This block sits between the external sensor timing pins and the converter output bus of an image signal front end. It brings the four sampling and clamping pulses (reference sample, data sample, black clamp, dummy clamp) to one internal convention: active low, whatever polarity the software has selected. It also derives the dummy-pixel clamp enable. In standby it holds every conditioned pulse and the conversion clock gate at the inactive high level.

On the data side, each 12-bit converter sample passes through a fixed nine-stage register pipeline. A small output-mode state machine chooses between passing the pipeline output and forcing zeros. Its three states are `MODE_RUN` (pass data), `MODE_BLANK` (preblank, zeros) and `MODE_SLEEP` (standby, zeros). The transitions are:
- any state to `MODE_SLEEP` when standby is sampled high;
- `MODE_RUN` and `MODE_BLANK` swap as the delayed preblank level changes;
- `MODE_SLEEP` leaves to `MODE_RUN` or `MODE_BLANK` when standby is sampled low.

The preblank pin is delayed so that blanking and its release both take effect on the 11th clock edge. A 2-bit output-delay select is passed through unchanged for the analog output stage.

Top module: `ccd_pulse_pipe`

## Requirements
- R1: Each conditioned pulse output is low exactly when its raw input equals its polarity bit, and high otherwise (outside standby). `pol_sel[0]` governs the dummy clamp pulse, `pol_sel[1]` the black clamp pulse, and `pol_sel[2]` both the reference and the data sample pulses. A polarity value of 0 means active low and 1 means active high.
- R2: `dmclamp_en` is 1 only when the conditioned dummy clamp pulse and the conditioned reference sample pulse are both active (low), and is 0 in standby.
- R3: While `standby` is 1, all four conditioned pulse outputs and `conv_hold` are 1, with no clock delay. `conv_hold` is 0 when `standby` is 0.
- R4: In `MODE_RUN`, a sample presented on `sample` before rising edge k appears on `dout` right after edge k+8. This is the 9th rising edge, counting the edge that captures it.
- R5: If `pblk_n` is low before edge k, `dout` is all zeros right after edge k+10 (the 11th edge counting the capturing edge). A return of `pblk_n` to high releases the blanking on the same 11th-edge alignment.
- R6: If `standby` is 1 before a rising edge, `dout` is all zeros right after that edge, and stays zero for as long as standby stays sampled high.
- R7: While `rst_n` is low and until nine samples have been clocked after its release, `dout` is zero. Reset puts the state machine in `MODE_RUN` with the preblank delay line filled with the not-blanking level.
- R8: `dly_sel_out` always equals `dly_sel_in`.
- R9: Data is straight binary. A passed sample appears on `dout` bit for bit, with no recoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_shp | input | 1 | Raw reference sample pulse |
| raw_shd | input | 1 | Raw data sample pulse |
| raw_clpob | input | 1 | Raw black level clamp pulse |
| raw_clpdm | input | 1 | Raw dummy pixel clamp pulse |
| pol_sel | input | 3 | Polarity select per pulse group |
| standby | input | 1 | Standby request, 1 = standby |
| pblk_n | input | 1 | Preblank pin, low = blank |
| sample | input | 12 | Converter sample for this cycle |
| dly_sel_in | input | 2 | Output delay select from register |
| shp_n | output | 1 | Conditioned reference sample pulse, active low |
| shd_n | output | 1 | Conditioned data sample pulse, active low |
| clpob_n | output | 1 | Conditioned black clamp pulse, active low |
| clpdm_n | output | 1 | Conditioned dummy clamp pulse, active low |
| dmclamp_en | output | 1 | Dummy pixel clamp enable |
| conv_hold | output | 1 | Conversion clock gate held high in standby |
| dout | output | 12 | Output data bus |
| dly_sel_out | output | 2 | Output delay select to the analog stage |

## Verification
A corrupted data stage shows up as a wrong word on `dout` exactly nine edges after the affected sample. A wrong stage count shifts every word by a cycle, which is seen on the first nonzero output. A fault in the preblank delay line or in the mode state shows as zeros arriving, or lifting, one or more edges off the 11th-edge alignment. It can also show as zeros that persist after standby ends. Polarity or clamp-enable faults show at once on the combinational pulse outputs, in the same cycle the raw inputs change.

// File: rtl/ccdp_pkg.sv
package ccdp_pkg;
    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_BLANK = 2'd1,
        MODE_SLEEP = 2'd2
    } out_mode_t;

    localparam int PULSE_CNT = 4;
    localparam int IDX_CLPDM = 0;
    localparam int IDX_CLPOB = 1;
    localparam int IDX_SHP   = 2;
    localparam int IDX_SHD   = 3;
endpackage

// File: rtl/ccdp_delay_line.sv
module ccdp_delay_line #(
    parameter int W       = 12,
    parameter int DEPTH   = 9,
    parameter bit RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= {W{RST_VAL}};
                else        stg[g] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= {W{RST_VAL}};
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign dout = stg[DEPTH-1];
endmodule

// File: rtl/ccdp_pulse_cond.sv
module ccdp_pulse_cond #(
    parameter int N = 4
) (
    input  logic [N-1:0] raw,
    input  logic [N-1:0] pol,
    input  logic         standby,
    output logic [N-1:0] cond_n
);
    for (genvar g = 0; g < N; g++) begin : g_pulse
        always_comb begin
            if (standby) cond_n[g] = 1'b1;
            else         cond_n[g] = (raw[g] != pol[g]);
        end
    end
endmodule

// File: rtl/ccd_pulse_pipe.sv
module ccd_pulse_pipe #(
    parameter int DATA_W    = 12,
    parameter int DATA_LAT  = 9,
    parameter int BLANK_LAT = 11,
    parameter int POL_W     = 3,
    parameter int DSEL_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_shp,
    input  logic              raw_shd,
    input  logic              raw_clpob,
    input  logic              raw_clpdm,
    input  logic [POL_W-1:0]  pol_sel,
    input  logic              standby,
    input  logic              pblk_n,
    input  logic [DATA_W-1:0] sample,
    input  logic [DSEL_W-1:0] dly_sel_in,
    output logic              shp_n,
    output logic              shd_n,
    output logic              clpob_n,
    output logic              clpdm_n,
    output logic              dmclamp_en,
    output logic              conv_hold,
    output logic [DATA_W-1:0] dout,
    output logic [DSEL_W-1:0] dly_sel_out
);
    import ccdp_pkg::*;

    // The mode register supplies the final stage of the blanking delay.
    localparam int PBLK_STAGES = BLANK_LAT - 1;

    logic [PULSE_CNT-1:0] raw_vec, pol_vec, cond_vec;
    logic [DATA_W-1:0]    pipe_out;
    logic                 pblk_late;
    out_mode_t            mode_q, mode_d;

    assign raw_vec[IDX_CLPDM] = raw_clpdm;
    assign raw_vec[IDX_CLPOB] = raw_clpob;
    assign raw_vec[IDX_SHP]   = raw_shp;
    assign raw_vec[IDX_SHD]   = raw_shd;
    assign pol_vec[IDX_CLPDM] = pol_sel[0];
    assign pol_vec[IDX_CLPOB] = pol_sel[1];
    assign pol_vec[IDX_SHP]   = pol_sel[2];
    assign pol_vec[IDX_SHD]   = pol_sel[2];

    ccdp_pulse_cond #(.N(PULSE_CNT)) u_cond (
        .raw     (raw_vec),
        .pol     (pol_vec),
        .standby (standby),
        .cond_n  (cond_vec)
    );

    assign clpdm_n    = cond_vec[IDX_CLPDM];
    assign clpob_n    = cond_vec[IDX_CLPOB];
    assign shp_n      = cond_vec[IDX_SHP];
    assign shd_n      = cond_vec[IDX_SHD];
    assign dmclamp_en = ~cond_vec[IDX_CLPDM] & ~cond_vec[IDX_SHP];
    assign conv_hold  = standby;
    assign dly_sel_out = dly_sel_in;

    ccdp_delay_line #(.W(DATA_W), .DEPTH(DATA_LAT), .RST_VAL(1'b0)) u_data (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sample),
        .dout  (pipe_out)
    );

    ccdp_delay_line #(.W(1), .DEPTH(PBLK_STAGES), .RST_VAL(1'b1)) u_pblk (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pblk_n),
        .dout  (pblk_late)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_RUN;
        else        mode_q <= mode_d;
    end

    // Next-state logic
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_RUN: begin
                if (standby)         mode_d = MODE_SLEEP;
                else if (!pblk_late) mode_d = MODE_BLANK;
            end
            MODE_BLANK: begin
                if (standby)         mode_d = MODE_SLEEP;
                else if (pblk_late)  mode_d = MODE_RUN;
            end
            MODE_SLEEP: begin
                if (!standby)        mode_d = pblk_late ? MODE_RUN : MODE_BLANK;
            end
            default:                 mode_d = MODE_RUN;
        endcase
    end

    // Output logic
    always_comb begin
        unique case (mode_q)
            MODE_RUN:   dout = pipe_out;
            MODE_BLANK: dout = '0;
            MODE_SLEEP: dout = '0;
            default:    dout = '0;
        endcase
    end
endmodule

// File: rtl/ccdp_checker.sv
module ccdp_checker #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              standby,
    input logic              pblk_n,
    input logic [DATA_W-1:0] sample,
    input logic [DATA_W-1:0] dout,
    input logic              shp_n,
    input logic              shd_n,
    input logic              clpob_n,
    input logic              clpdm_n,
    input logic              dmclamp_en,
    input logic              conv_hold
);
    logic [3:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cyc <= '0;
        else if (cyc != 4'hF)  cyc <= cyc + 4'd1;
    end

    assert_clamp_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dmclamp_en |-> (!clpdm_n && !shp_n));

    assert_sleep_pulses_R3: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (shp_n && shd_n && clpob_n && clpdm_n && conv_hold && !dmclamp_en));

    assert_data_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 4'd9 && dout != '0) |-> (dout == $past(sample, 9)));

    assert_blank_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 4'd11 && $past(pblk_n, 11) == 1'b0) |-> (dout == '0));

    assert_sleep_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 4'd1 && $past(standby)) |-> (dout == '0));

    assert_reset_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc < 4'd9) |-> (dout == '0));
endmodule

bind ccd_pulse_pipe ccdp_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .standby    (standby),
    .pblk_n     (pblk_n),
    .sample     (sample),
    .dout       (dout),
    .shp_n      (shp_n),
    .shd_n      (shd_n),
    .clpob_n    (clpob_n),
    .clpdm_n    (clpdm_n),
    .dmclamp_en (dmclamp_en),
    .conv_hold  (conv_hold)
);

// File: tb/ccd_pulse_pipe_test.sv
module ccd_pulse_pipe_test;
    localparam int NCYC = 600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        raw_shp = 0, raw_shd = 0, raw_clpob = 0, raw_clpdm = 0;
    logic [2:0]  pol_sel = '0;
    logic        standby = 0, pblk_n = 1;
    logic [11:0] sample = '0;
    logic [1:0]  dly_sel_in = '0;
    logic        shp_n, shd_n, clpob_n, clpdm_n, dmclamp_en, conv_hold;
    logic [11:0] dout;
    logic [1:0]  dly_sel_out;

    int checks = 0, failures = 0;
    logic [11:0] h_smp [NCYC];
    logic        h_pblk [NCYC];
    logic        h_sby [NCYC];
    bit          done = 0;

    always #4 clk = ~clk;   // 125 MHz

    ccd_pulse_pipe uut (
        .clk(clk), .rst_n(rst_n), .raw_shp(raw_shp), .raw_shd(raw_shd),
        .raw_clpob(raw_clpob), .raw_clpdm(raw_clpdm), .pol_sel(pol_sel),
        .standby(standby), .pblk_n(pblk_n), .sample(sample),
        .dly_sel_in(dly_sel_in), .shp_n(shp_n), .shd_n(shd_n),
        .clpob_n(clpob_n), .clpdm_n(clpdm_n), .dmclamp_en(dmclamp_en),
        .conv_hold(conv_hold), .dout(dout), .dly_sel_out(dly_sel_out)
    );

    function automatic logic cond_of(input logic raw, input logic pol, input logic sby);
        return sby ? 1'b1 : (raw != pol);
    endfunction

    function automatic logic [11:0] exp_dout(input int k);
        if (h_sby[k]) return 12'd0;
        if (k >= 10 && h_pblk[k-10] == 1'b0) return 12'd0;
        if (k >= 8) return h_smp[k-8];
        return 12'd0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic chk_pulses();
        chk("R1/R3 shp_n", shp_n, cond_of(raw_shp, pol_sel[2], standby));
        chk("R1/R3 shd_n", shd_n, cond_of(raw_shd, pol_sel[2], standby));
        chk("R1/R3 clpob_n", clpob_n, cond_of(raw_clpob, pol_sel[1], standby));
        chk("R1/R3 clpdm_n", clpdm_n, cond_of(raw_clpdm, pol_sel[0], standby));
        chk("R2 dmclamp_en", dmclamp_en,
            !standby && (raw_clpdm == pol_sel[0]) && (raw_shp == pol_sel[2]));
        chk("R3 conv_hold", conv_hold, standby);
        chk("R8 dly_sel_out", dly_sel_out, dly_sel_in);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd2718));
        // reset state: R7
        repeat (3) @(negedge clk);
        sample = 12'hABC;
        #1;
        chk("R7 dout in reset", dout, 12'd0);
        chk_pulses();
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < NCYC; k++) begin
            // stimulus for edge k
            raw_shp   = $urandom_range(0, 1);
            raw_shd   = $urandom_range(0, 1);
            raw_clpob = $urandom_range(0, 1);
            raw_clpdm = $urandom_range(0, 1);
            if ($urandom_range(0, 15) == 0) pol_sel = 3'($urandom_range(0, 7));
            dly_sel_in = 2'($urandom_range(0, 3));
            sample = 12'($urandom_range(1, 4095));
            if (k == 20) sample = 12'hFFF;          // all-ones word, R9
            if (k == 21) sample = 12'h001;
            if (k >= 40 && k < 60)        pblk_n = (k < 43) ? 1'b0 : 1'b1; // short blank
            else if (k >= 100 && k < 140) pblk_n = !(k >= 105 && k < 125);
            else if (k >= 140 && ($urandom_range(0, 9) == 0)) pblk_n = ~pblk_n;
            if (k >= 200 && k < 215)      standby = 1'b1;
            else if (k >= 300 && ($urandom_range(0, 19) == 0)) standby = ~standby;
            else if (k < 300)             standby = 1'b0;
            if (k == 205) pblk_n = 1'b0;            // blank begins inside standby
            h_smp[k] = sample; h_pblk[k] = pblk_n; h_sby[k] = standby;
            #1;
            chk_pulses();
            @(posedge clk);
            @(negedge clk);
            begin
                logic [11:0] e;
                e = exp_dout(k);
                if (h_sby[k])                               chk("R6 standby zero", dout, e);
                else if (k >= 10 && h_pblk[k-10] == 1'b0)   chk("R5 blank zero", dout, e);
                else if (k < 8)                             chk("R7 empty pipe", dout, e);
                else                                        chk("R4 R9 latency data", dout, e);
            end
        end
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule